// File: doc/BRIEF.md
# Register Renamer with Exception Rollback

This block maps a small set of architected general registers onto a larger pool of physical register tags. Each register write made by an instruction, including the side-effect updates of self-modifying addressing modes, gets a newly allocated physical tag. The tag it replaces is left untouched until the instruction commits. If the instruction faults, the map is put back in one cycle to the copy taken when the instruction began. Every tag the instruction allocated goes back to the free pool in that same cycle. No record of individual modifications is kept and nothing is unwound step by step.

Microop temporaries are drawn from the same pool. They leave the map unchanged and are released at commit or rollback. A fast-interrupt mode gives a handler a configurable group of fresh registers in a single cycle, so the handler does not have to save their previous contents first. When the handler leaves, the fresh tags are released and the original mappings come back.

Top module: `reg_renamer`

## Requirements
- R1: After reset, architected register i maps to physical tag i, tags NUM_ARCH and above are free, and `alloc_stall` is low.
- R2: A non-temporary write request inside an open instruction returns the lowest-numbered free tag on `wr_tag` in the same cycle. From the next cycle, a lookup of that register returns that tag.
- R3: A tag that was displaced during an open instruction, or that was mapped when the instruction began, is not handed out again before the instruction ends.
- R4: A fault (`ins_fault`) during an open instruction restores every mapping to its state at `ins_start` and frees every tag allocated since then, all in one cycle.
- R5: A retire (`ins_retire`) frees the tags displaced by the instruction and its temporaries. The tags it mapped stay in use.
- R6: A temporary write (`wr_temp` high) allocates the lowest free tag and leaves every mapping unchanged.
- R7: A write request inside an open instruction while no tag is free raises `alloc_stall` in that cycle and changes neither the map nor the pool.
- R8: A write request while no instruction is open has no effect on the map or the pool.
- R9: `fint_enter`, with no instruction open and no interrupt active, remaps the top FRESH_REGS architected registers. Register NUM_ARCH-FRESH_REGS+j receives the j-th lowest free tag. If fewer than FRESH_REGS tags are free, `alloc_stall` rises and nothing changes.
- R10: `fint_leave`, with an interrupt active and no instruction open, frees the tags those registers currently map and restores the mappings they had before entry.
- R11: If fault and retire arrive in the same cycle, the fault wins.
- R12: Priority order is fault, retire, start (only when no instruction is open), interrupt entry, interrupt exit, then write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Request a fresh tag for a register write |
| wr_temp | input | 1 | Request is a microop temporary, not mapped |
| wr_arch | input | ARCH_W | Architected register being written |
| wr_tag | output | TAG_W | Tag granted this cycle (lowest free) |
| alloc_stall | output | 1 | Request could not be served, pool short |
| lk_arch | input | ARCH_W | Architected register to look up |
| lk_tag | output | TAG_W | Tag currently mapped to `lk_arch` |
| ins_start | input | 1 | Instruction begins, checkpoint the map |
| ins_retire | input | 1 | Instruction commits |
| ins_fault | input | 1 | Instruction faults, roll back |
| fint_enter | input | 1 | Enter fast interrupt mode |
| fint_leave | input | 1 | Leave fast interrupt mode |

## Verification
The hardest state to reach is an empty pool. At the defaults, 48 tags are free outside an instruction, so a single instruction has to issue more than 48 writes before stalling. Random instructions stay far shorter than that. A directed sequence therefore opens an instruction and issues temporaries until the pool is exhausted. It then checks the stall and the unchanged map, and rolls back to show every tag returns. The random phase interleaves interrupt entry and exit with faulting and retiring instructions, so handler writes to the fresh registers are also released correctly on exit.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_ABORT  = 3'd1,
    ACT_COMMIT = 3'd2,
    ACT_BEGIN  = 3'd3,
    ACT_ENTER  = 3'd4,
    ACT_EXIT   = 3'd5,
    ACT_REN    = 3'd6
  } rn_act_e;
endpackage

// File: rtl/rn_pick.sv
module rn_pick #(
  parameter int NP = 64,
  localparam int TW = $clog2(NP)
) (
  input  logic [NP-1:0] avail,
  output logic          found,
  output logic [TW-1:0] idx
);
  // lowest set bit wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NP - 1; i >= 0; i--) begin
      if (avail[i]) begin
        found = 1'b1;
        idx   = TW'(i);
      end
    end
  end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool
  import rn_pkg::*;
#(
  parameter int NP = 64,
  parameter int NA = 16,
  parameter int K  = 6,
  localparam int TW = $clog2(NP)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rn_act_e              act,
  input  logic                 temp,
  input  logic [TW-1:0]        old_tag,
  input  logic [NP-1:0]        leave_mask,
  output logic [K-1:0][TW-1:0] pick_tag,
  output logic [K-1:0]         pick_ok
);
  logic [NP-1:0] free_q, free_d;
  logic [NP-1:0] infl_q, infl_d;   // allocated since start
  logic [NP-1:0] ret_q, ret_d;     // to release on retire
  logic [NP-1:0] alloc_m, rel_m, new_oh, old_oh;
  logic [K-1:0][NP-1:0] avail;
  logic          pool_en, trk_en;

  assign avail[0] = free_q;

  genvar k;
  generate
    for (k = 0; k < K; k++) begin : g_pick
      rn_pick #(.NP(NP)) u_pick (
        .avail (avail[k]),
        .found (pick_ok[k]),
        .idx   (pick_tag[k])
      );
      if (k < K - 1) begin : g_chain
        assign avail[k+1] = avail[k] &
          ~(pick_ok[k] ? (NP'(1) << pick_tag[k]) : '0);
      end
    end
  endgenerate

  assign new_oh = NP'(1) << pick_tag[0];
  assign old_oh = NP'(1) << old_tag;

  always_comb begin
    alloc_m = '0;
    rel_m   = '0;
    infl_d  = infl_q;
    ret_d   = ret_q;
    unique case (act)
      ACT_ABORT: begin
        rel_m  = infl_q;
        infl_d = '0;
        ret_d  = '0;
      end
      ACT_COMMIT: begin
        rel_m  = ret_q;
        infl_d = '0;
        ret_d  = '0;
      end
      ACT_ENTER: begin
        for (int j = 0; j < K; j++) alloc_m |= NP'(1) << pick_tag[j];
      end
      ACT_EXIT: rel_m = leave_mask;
      ACT_REN: begin
        alloc_m = new_oh;
        infl_d  = infl_q | new_oh;
        ret_d   = ret_q | (temp ? new_oh : old_oh);
      end
      default: ;
    endcase
    free_d = (free_q & ~alloc_m) | rel_m;
  end

  assign pool_en = (act != ACT_IDLE) && (act != ACT_BEGIN);
  assign trk_en  = (act == ACT_ABORT) || (act == ACT_COMMIT) || (act == ACT_REN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) free_q[i] <= (i >= NA);
      infl_q <= '0;
      ret_q  <= '0;
    end else begin
      if (pool_en) free_q <= free_d;
      if (trk_en) begin
        infl_q <= infl_d;
        ret_q  <= ret_d;
      end
    end
  end

  // only free tags are handed out
  p_alloc_from_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_m & ~free_q) == '0);
  // a release never targets a tag already free
  p_release_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_m & free_q) == '0);
  // after rollback nothing allocated since start stays in flight
  p_abort_drains_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ABORT) |=> (infl_q == '0) && ((free_q & $past(infl_q)) == $past(infl_q)));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
#(
  parameter int NA = 16,
  parameter int NP = 64,
  parameter int K  = 6,
  localparam int TW   = $clog2(NP),
  localparam int AW   = $clog2(NA),
  localparam int BASE = NA - K
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  rn_act_e               act,
  input  logic                  temp,
  input  logic [AW-1:0]         arch,
  input  logic [TW-1:0]         new_tag,
  input  logic [K-1:0][TW-1:0]  fresh,
  output logic [NA-1:0][TW-1:0] map_o
);
  logic [NA-1:0][TW-1:0] map_q, map_d, ckpt_q, ckpt_d;
  logic [K-1:0][TW-1:0]  save_q, save_d;
  logic map_en, ckpt_en, save_en;

  always_comb begin
    map_d  = map_q;
    ckpt_d = ckpt_q;
    save_d = save_q;
    unique case (act)
      ACT_ABORT: map_d  = ckpt_q;
      ACT_BEGIN: ckpt_d = map_q;
      ACT_ENTER: begin
        for (int j = 0; j < K; j++) begin
          save_d[j]       = map_q[BASE+j];
          map_d[BASE+j]   = fresh[j];
        end
      end
      ACT_EXIT: begin
        for (int j = 0; j < K; j++) map_d[BASE+j] = save_q[j];
      end
      ACT_REN: if (!temp) map_d[arch] = new_tag;
      default: ;
    endcase
  end

  assign map_en  = (act == ACT_ABORT) || (act == ACT_ENTER) ||
                   (act == ACT_EXIT)  || ((act == ACT_REN) && !temp);
  assign ckpt_en = (act == ACT_BEGIN);
  assign save_en = (act == ACT_ENTER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) begin
        map_q[i]  <= TW'(i);
        ckpt_q[i] <= TW'(i);
      end
      save_q <= '0;
    end else begin
      if (map_en)  map_q  <= map_d;
      if (ckpt_en) ckpt_q <= ckpt_d;
      if (save_en) save_q <= save_d;
    end
  end

  assign map_o = map_o_w;
  logic [NA-1:0][TW-1:0] map_o_w;
  assign map_o_w = map_q;

  // rollback lands exactly on the checkpoint
  p_rollback_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_ABORT) |=> map_q == $past(ckpt_q));
  // temporaries never touch the map
  p_temp_no_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_REN && temp) |=> map_q == $past(map_q));
  // leaving the interrupt brings back the saved mappings
  p_leave_restores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_EXIT) |=> map_q[NA-1] == $past(save_q[K-1]));
endmodule

// File: rtl/reg_renamer.sv
module reg_renamer
  import rn_pkg::*;
#(
  parameter int NUM_ARCH     = 16,
  parameter int NUM_PHYS     = 64,
  parameter int FRESH_REGS   = 6,
  parameter int WORST_WRITES = 8,
  localparam int ARCH_W = $clog2(NUM_ARCH),
  localparam int TAG_W  = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_temp,
  input  logic [ARCH_W-1:0] wr_arch,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              alloc_stall,
  input  logic [ARCH_W-1:0] lk_arch,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              ins_start,
  input  logic              ins_retire,
  input  logic              ins_fault,
  input  logic              fint_enter,
  input  logic              fint_leave
);
  localparam int BASE = NUM_ARCH - FRESH_REGS;

  generate
    if (NUM_PHYS < NUM_ARCH + FRESH_REGS + WORST_WRITES) begin : g_pool_small
      $error("physical pool too small for worst-case instruction");
    end
    if (FRESH_REGS < 5 || FRESH_REGS > 8) begin : g_fresh_range
      $error("fresh register count must lie in 5..8");
    end
  endgenerate

  logic                            open_q, open_d, irq_q, irq_d;
  rn_act_e                         act;
  logic [FRESH_REGS-1:0][TAG_W-1:0] pick_tag;
  logic [FRESH_REGS-1:0]           pick_ok;
  logic [NUM_ARCH-1:0][TAG_W-1:0]  map;
  logic [NUM_PHYS-1:0]             leave_mask;
  logic                            ren_live, enter_live;

  assign ren_live   = wr_req && open_q && !ins_fault && !ins_retire;
  assign enter_live = fint_enter && !open_q && !irq_q && !ins_start;

  always_comb begin
    act = ACT_IDLE;
    if (ins_fault && open_q)                       act = ACT_ABORT;
    else if (ins_retire && open_q)                 act = ACT_COMMIT;
    else if (ins_start && !open_q)                 act = ACT_BEGIN;
    else if (enter_live && pick_ok[FRESH_REGS-1])  act = ACT_ENTER;
    else if (fint_leave && !open_q && irq_q)       act = ACT_EXIT;
    else if (ren_live && pick_ok[0])               act = ACT_REN;
  end

  assign alloc_stall = (ren_live && !pick_ok[0]) ||
                       (enter_live && !pick_ok[FRESH_REGS-1]);

  always_comb begin
    leave_mask = '0;
    for (int j = 0; j < FRESH_REGS; j++)
      leave_mask |= NUM_PHYS'(1) << map[BASE+j];
  end

  always_comb begin
    open_d = open_q;
    irq_d  = irq_q;
    unique case (act)
      ACT_ABORT, ACT_COMMIT: open_d = 1'b0;
      ACT_BEGIN:             open_d = 1'b1;
      ACT_ENTER:             irq_d  = 1'b1;
      ACT_EXIT:              irq_d  = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      open_q <= open_d;
      irq_q  <= irq_d;
    end
  end

  rn_free_pool #(.NP(NUM_PHYS), .NA(NUM_ARCH), .K(FRESH_REGS)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .act        (act),
    .temp       (wr_temp),
    .old_tag    (map[wr_arch]),
    .leave_mask (leave_mask),
    .pick_tag   (pick_tag),
    .pick_ok    (pick_ok)
  );

  rn_map_table #(.NA(NUM_ARCH), .NP(NUM_PHYS), .K(FRESH_REGS)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .act     (act),
    .temp    (wr_temp),
    .arch    (wr_arch),
    .new_tag (pick_tag[0]),
    .fresh   (pick_tag),
    .map_o   (map)
  );

  assign wr_tag = pick_tag[0];
  assign lk_tag = map[lk_arch];

  // a stalled request leaves the map alone
  p_stall_holds_map_r7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_stall |=> map == $past(map));
  // writes with no open instruction do nothing
  p_outside_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !open_q && !ins_start && !fint_enter && !fint_leave) |=> map == $past(map));
  // fault together with retire closes the instruction by rollback
  p_fault_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && ins_fault && ins_retire) |=> !open_q);
  // a granted write maps the granted tag next cycle
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_live && !wr_temp && !alloc_stall) |=> map[$past(wr_arch)] == $past(wr_tag));
endmodule

// File: tb/test_reg_renamer.sv
module test_reg_renamer;
  localparam int NA = 16;
  localparam int NP = 64;
  localparam int K  = 6;
  localparam int B  = NA - K;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_req, wr_temp, ins_start, ins_retire, ins_fault, fint_enter, fint_leave;
  logic [3:0] wr_arch, lk_arch;
  logic [5:0] wr_tag, lk_tag;
  logic alloc_stall;

  always #4 clk = ~clk;

  reg_renamer #(.NUM_ARCH(NA), .NUM_PHYS(NP), .FRESH_REGS(K)) i_reg_renamer (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_temp(wr_temp),
    .wr_arch(wr_arch), .wr_tag(wr_tag), .alloc_stall(alloc_stall),
    .lk_arch(lk_arch), .lk_tag(lk_tag), .ins_start(ins_start),
    .ins_retire(ins_retire), .ins_fault(ins_fault),
    .fint_enter(fint_enter), .fint_leave(fint_leave));

  int n_chk = 0;
  int n_bad = 0;

  int mmap[NA];
  int ckpt[NA];
  int sv[K];
  bit fr[NP];
  bit infl[NP];
  bit ret[NP];
  bit open_m, irq_m;

  function automatic int low_free(input int skip);
    int seen = 0;
    for (int t = 0; t < NP; t++) begin
      if (fr[t]) begin
        if (seen == skip) return t;
        seen++;
      end
    end
    return -1;
  endfunction

  function automatic int nfree();
    int c = 0;
    for (int t = 0; t < NP; t++) c += int'(fr[t]);
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_req = 0; wr_temp = 0; wr_arch = '0; ins_start = 0; ins_retire = 0;
    ins_fault = 0; fint_enter = 0; fint_leave = 0;
  endtask

  // one clock: inputs already driven after a falling edge
  task automatic step(input string lbl);
    bit rl, el;
    int tg;
    int picks[K];
    #1;
    rl = wr_req && open_m && !ins_fault && !ins_retire;
    el = fint_enter && !open_m && !irq_m && !ins_start;
    check("R7/R9 stall", int'(alloc_stall),
          int'((rl && nfree() == 0) || (el && nfree() < K)));
    if (rl && nfree() > 0) check("R2 granted tag", int'(wr_tag), low_free(0));
    check(lbl, int'(lk_tag), mmap[lk_arch]);
    @(posedge clk);
    if (ins_fault && open_m) begin
      for (int t = 0; t < NP; t++) if (infl[t]) fr[t] = 1;
      mmap = ckpt;
      infl = '{default: 0}; ret = '{default: 0}; open_m = 0;
    end else if (ins_retire && open_m) begin
      for (int t = 0; t < NP; t++) if (ret[t]) fr[t] = 1;
      infl = '{default: 0}; ret = '{default: 0}; open_m = 0;
    end else if (ins_start && !open_m) begin
      ckpt = mmap; open_m = 1;
    end else if (el && nfree() >= K) begin
      for (int j = 0; j < K; j++) picks[j] = low_free(j);
      for (int j = 0; j < K; j++) begin
        sv[j] = mmap[B+j]; mmap[B+j] = picks[j]; fr[picks[j]] = 0;
      end
      irq_m = 1;
    end else if (fint_leave && !open_m && irq_m) begin
      for (int j = 0; j < K; j++) begin
        fr[mmap[B+j]] = 1; mmap[B+j] = sv[j];
      end
      irq_m = 0;
    end else if (rl && nfree() > 0) begin
      tg = low_free(0);
      fr[tg] = 0; infl[tg] = 1;
      if (wr_temp) ret[tg] = 1;
      else begin ret[mmap[wr_arch]] = 1; mmap[wr_arch] = tg; end
    end
    @(negedge clk);
    idle_inputs();
    lk_arch = 4'($urandom_range(0, NA - 1));
  endtask

  task automatic do_write(input int a, input bit t, input string lbl);
    wr_req = 1; wr_temp = t; wr_arch = 4'(a); step(lbl);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int r;
    int ilen;
    void'($urandom(32'h5EED_0042));
    idle_inputs();
    lk_arch = '0;
    rst_n = 0;
    for (int i = 0; i < NA; i++) begin mmap[i] = i; ckpt[i] = i; end
    for (int t = 0; t < NP; t++) begin fr[t] = (t >= NA); infl[t] = 0; ret[t] = 0; end
    open_m = 0; irq_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset map and stall
    for (int i = 0; i < NA; i++) begin
      lk_arch = 4'(i); #1;
      check("R1 reset map", int'(lk_tag), i);
    end
    check("R1 reset stall", int'(alloc_stall), 0);
    @(negedge clk);

    // R2 / R3 / R5: double write then retire
    ins_start = 1; step("R2 start");
    do_write(3, 0, "R2 write");
    lk_arch = 4'd3; do_write(3, 0, "R2 lookup new tag");
    check("R3 no reuse of displaced", int'(wr_tag == 6'd16 || wr_tag == 6'd3), 0);
    ins_retire = 1; step("R5 retire");
    lk_arch = 4'd3; ins_start = 1; step("R5 map kept");
    do_write(5, 0, "R5 freed tag reused");
    check("R5 lowest freed", int'(mmap[5]), 3);
    ins_retire = 1; step("R5 retire2");

    // R6 temporary
    ins_start = 1; step("R6 start");
    lk_arch = 4'd7; do_write(7, 1, "R6 temp");
    lk_arch = 4'd7; step("R6 map unchanged");
    ins_retire = 1; step("R6 retire");

    // R4 / R11 rollback beats retire
    ins_start = 1; step("R4 start");
    do_write(0, 0, "R4 w0");
    do_write(1, 0, "R4 w1");
    ins_fault = 1; ins_retire = 1; step("R11 fault+retire");
    lk_arch = 4'd0; step("R4 r0 restored");
    lk_arch = 4'd1; step("R4 r1 restored");
    check("R4 pool refilled", nfree(), NP - NA);

    // R7 exhaust pool with temporaries
    ins_start = 1; step("R7 start");
    for (int i = 0; i < NP - NA; i++) do_write(i % NA, 1, "R7 fill");
    lk_arch = 4'd2; do_write(2, 0, "R7 stalled write");
    lk_arch = 4'd2; step("R7 map held");
    ins_fault = 1; step("R7 rollback");
    check("R7 pool back", nfree(), NP - NA);

    // R8 writes outside an instruction
    lk_arch = 4'd4; do_write(4, 0, "R8 outside");
    lk_arch = 4'd4; step("R8 map unchanged");

    // R9 / R10 fast interrupt
    fint_enter = 1; step("R9 enter");
    for (int j = 0; j < K; j++) begin
      lk_arch = 4'(B + j); step("R9 fresh map");
    end
    ins_start = 1; step("R10 handler start");
    do_write(NA - 1, 0, "R10 handler write");
    ins_retire = 1; step("R10 handler retire");
    fint_leave = 1; step("R10 leave");
    for (int j = 0; j < K; j++) begin
      lk_arch = 4'(B + j); step("R10 restored");
    end
    check("R10 pool back", nfree(), NP - NA);

    // R12 random mix
    for (int it = 0; it < 2500; it++) begin
      r = $urandom_range(0, 99);
      if (!open_m) begin
        if (r < 55) ins_start = 1;
        else if (r < 70) fint_enter = 1;
        else if (r < 85) fint_leave = 1;
        else if (r < 93) begin wr_req = 1; wr_arch = 4'($urandom_range(0, NA - 1)); end
        step("R12 random idle");
      end else begin
        ilen = $urandom_range(1, 10);
        for (int w = 0; w < ilen; w++)
          do_write($urandom_range(0, NA - 1), $urandom_range(0, 4) == 0, "R3 random write");
        r = $urandom_range(0, 99);
        if (r < 60) ins_retire = 1;
        else if (r < 90) ins_fault = 1;
        else begin ins_fault = 1; ins_retire = 1; end
        if ($urandom_range(0, 3) == 0) fint_enter = 1;
        step("R12 random close");
      end
    end
    summary();
  end
endmodule